// File: doc/BRIEF.md
# Operation Timeout Countdown Timer

This block puts a time limit on an operation that may never finish, such as a memory or I/O request that stays pending because of a priority conflict or a hardware fault. Software writes a starting count, then turns the counter on. On every tick from the shared timebase, and only while the processor reports that it is running, the count drops by one. When an armed, enabled count runs out, a sticky timeout flag is raised on `irq`. The processor can use that to drop the hold on its main timing.

Three write addresses hold all the control: one selects the enable state, one loads the count, and one acknowledges the flag by writing 1 to clear it. The same addresses can be read back to give the enable state, the flag and the live count. A load arms the counter for exactly one timeout. After the timeout fires, the count stays at zero and does not wrap, and it raises nothing more until the next load.

Top module: `mon_timeout_timer`

## Requirements
- R1: After reset the count reads 0, the counter is disabled, the flag and `irq` are 0, and the counter is unarmed, so ticks raise nothing.
- R2: A write to address 1 loads `wr_data` into the count, which can be read at address 1 on the next cycle. A load changes neither the enable state nor the flag.
- R3: On each clock edge where the counter is enabled and `tick` and `cpu_run` are both 1, a nonzero count decreases by exactly one.
- R4: The count holds when `cpu_run` is 0 or when `tick` is 0.
- R5: Writing address 0 sets the enable state to `wr_data[0]`. Address 0 bit 0 reads back the enable state. Disabling the counter freezes the count at its present value.
- R6: The qualifying tick that takes an armed count from 1 to 0 sets the flag and `irq` on that same edge. Address 0 bit 1 reads back the flag. Later ticks leave the count at 0, with no wrap.
- R7: If the count is loaded with 0 while enabled, the flag is raised by the next qualifying tick and not before it.
- R8: The flag stays set until a write to address 2 with `wr_data[0]`=1. Writing 0 there, or reloading the count, leaves the flag set.
- R9: Each load allows at most one timeout. After an acknowledge, further ticks at count 0 raise nothing until the next load.
- R10: When a timeout and an acknowledge fall in the same cycle, the flag ends up set.
- R11: When a load and a qualifying tick fall in the same cycle, the count takes the loaded value and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle pulse from the shared timebase |
| cpu_run | input | 1 | High while the processor is running |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 enable, 1 load, 2 acknowledge |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 {flag, enable}, 1 count, others 0 |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Sticky timeout interrupt |

## Verification
Two pairs of events can land on the same clock edge: a timeout with its acknowledge, and a load with a qualifying tick. The bench drives each pair in a single cycle. In the first case it takes an armed count of 1 and asserts `tick` while writing the acknowledge, and it expects `irq` to still be high afterwards. In the second case it drives a load together with a tick, and it expects the count to read back exactly the loaded value rather than one less.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    MT_REG_CTRL  = 2'd0,
    MT_REG_COUNT = 2'd1,
    MT_REG_ACK   = 2'd2,
    MT_REG_NONE  = 2'd3
  } mt_reg_e;
endpackage

// File: rtl/mt_rst_sync.sv
module mt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/mt_down_counter.sv
module mt_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             adv;
  logic             at_last;

  always_comb begin
    adv     = run_en & step & ~load;
    at_last = (cnt_q[CNT_W-1:1] == '0);
    hit     = adv & armed_q & at_last;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (load) begin
      cnt_d   = load_val;
      armed_d = 1'b1;
    end else if (adv) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      if (hit)         armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign count = cnt_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
  p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && step && !load && cnt_q != '0) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(run_en && step)) |=> $stable(cnt_q));
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> cnt_q == '0);
  p_one_shot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !load) |=> !armed_q);
endmodule

// File: rtl/mt_ctrl.sv
module mt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wr_ack,
  input  logic wbit,
  input  logic hit,
  output logic enable,
  output logic flag
);
  logic en_q, en_d;
  logic flag_q, flag_d;
  logic ack;

  always_comb begin
    ack    = wr_ack & wbit;
    en_d   = wr_ctrl ? wbit : en_q;
    flag_d = hit | (flag_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  assign enable = en_q;
  assign flag   = flag_q;

  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(en_q));
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack) |=> flag_q);
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !flag_q);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hit) |=> flag_q);
endmodule

// File: rtl/mon_timeout_timer.sv
module mon_timeout_timer
  import mt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cpu_run,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  logic             rst_sn;
  logic             wr_ctrl, wr_load, wr_ack;
  logic             enable, flag, hit;
  logic [CNT_W-1:0] count;

  mt_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  always_comb begin
    wr_ctrl = wr_en && (mt_reg_e'(wr_addr) == MT_REG_CTRL);
    wr_load = wr_en && (mt_reg_e'(wr_addr) == MT_REG_COUNT);
    wr_ack  = wr_en && (mt_reg_e'(wr_addr) == MT_REG_ACK);
  end

  mt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sn), .run_en(enable), .step(tick & cpu_run),
    .load(wr_load), .load_val(wr_data), .count(count), .hit(hit));

  mt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sn), .wr_ctrl(wr_ctrl), .wr_ack(wr_ack),
    .wbit(wr_data[0]), .hit(hit), .enable(enable), .flag(flag));

  always_comb begin
    rd_data = '0;
    case (mt_reg_e'(rd_addr))
      MT_REG_CTRL:  rd_data = {{(CNT_W-2){1'b0}}, flag, enable};
      MT_REG_COUNT: rd_data = count;
      default:      rd_data = '0;
    endcase
  end

  assign irq = flag;

  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    irq == rd_data[1] || mt_reg_e'(rd_addr) != MT_REG_CTRL);
endmodule

// File: tb/mon_timeout_timer_bench.sv
module mon_timeout_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cpu_run = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mon_timeout_timer u_mon_timeout_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cpu_run(cpu_run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd1, v); check("R1 count", v, 16'd0);
    rd(2'd0, v); check("R1 ctrl", v, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    cpu_run = 1'b1;
    wr(2'd0, 16'd1);
    ticks(3);
    check("R1 unarmed irq", {15'd0, irq}, 16'd0);
    wr(2'd0, 16'd0);
  endtask

  task automatic t_load;
    logic [15:0] v;
    wr(2'd1, 16'd10);
    rd(2'd1, v); check("R2 load", v, 16'd10);
    rd(2'd0, v); check("R2 ctrl unchanged", v, 16'd0);
  endtask

  task automatic t_gating;
    logic [15:0] v;
    wr(2'd0, 16'd1);
    cpu_run = 1'b0; ticks(3);
    rd(2'd1, v); check("R4 run low", v, 16'd10);
    cpu_run = 1'b1; repeat (4) @(negedge clk);
    rd(2'd1, v); check("R4 no tick", v, 16'd10);
    ticks(3);
    rd(2'd1, v); check("R3 decrement", v, 16'd7);
  endtask

  task automatic t_freeze;
    logic [15:0] v;
    wr(2'd0, 16'd0);
    rd(2'd0, v); check("R5 disabled status", v, 16'd0);
    ticks(3);
    rd(2'd1, v); check("R5 frozen", v, 16'd7);
    wr(2'd0, 16'd1);
    rd(2'd0, v); check("R5 enabled status", v, 16'd1);
  endtask

  task automatic t_expire;
    logic [15:0] v;
    ticks(6);
    rd(2'd1, v); check("R6 count one", v, 16'd1);
    check("R6 irq not yet", {15'd0, irq}, 16'd0);
    ticks(1);
    rd(2'd1, v); check("R6 zero", v, 16'd0);
    check("R6 irq", {15'd0, irq}, 16'd1);
    rd(2'd0, v); check("R6 flag status", v, 16'd3);
    ticks(2);
    rd(2'd1, v); check("R6 no wrap", v, 16'd0);
  endtask

  task automatic t_sticky;
    logic [15:0] v;
    wr(2'd2, 16'd0);
    check("R8 write 0 keeps", {15'd0, irq}, 16'd1);
    wr(2'd1, 16'd5);
    check("R8 reload keeps", {15'd0, irq}, 16'd1);
    rd(2'd1, v); check("R8 reload value", v, 16'd5);
    wr(2'd2, 16'd1);
    check("R8 ack clears", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_once;
    wr(2'd1, 16'd1);
    ticks(1);
    check("R9 fires", {15'd0, irq}, 16'd1);
    wr(2'd2, 16'd1);
    ticks(3);
    check("R9 no refire", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_zero_load;
    wr(2'd1, 16'd0);
    check("R7 not on load", {15'd0, irq}, 16'd0);
    ticks(1);
    check("R7 next tick", {15'd0, irq}, 16'd1);
    wr(2'd2, 16'd1);
  endtask

  task automatic t_collide_ack;
    wr(2'd1, 16'd1);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd1;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R10 set wins", {15'd0, irq}, 16'd1);
    wr(2'd2, 16'd1);
    check("R10 later ack", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_collide_load;
    logic [15:0] v;
    wr(2'd1, 16'd8);
    ticks(1);
    rd(2'd1, v); check("R11 pre", v, 16'd7);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd20;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(2'd1, v); check("R11 load wins", v, 16'd20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_load;
    t_gating;
    t_freeze;
    t_expire;
    t_sticky;
    t_once;
    t_zero_load;
    t_collide_ack;
    t_collide_load;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule